// File: doc/BRIEF.md
# Routed Interrupt Controller Core

This block collects level-sensitive interrupt lines, holds each as pending, and steers each one to one of several processor cores. Every interrupt has a small route byte that names its destination core. Every core has its own interrupt output and its own status bank. An interrupt reaches a core's output only while it is pending, enabled, routed to that core, and marked in that core's status bank.

Software reaches the block through a single-cycle register port. A write or read strobe comes with a 12-bit byte address, an access size of 1, 2, 4 or 8 bytes, 64-bit write data and the index of the core that makes the access. An access completes in the cycle it is presented. A misaligned or unmapped access raises an error flag for that cycle and changes nothing. The controller applies the side effects of a register write in the same clock edge that stores it:
- turning an enable on or off for a pending interrupt raises or drops the routed output;
- a write of 1 to a status bit clears that bit for the accessing core;
- moving a pending interrupt to another core carries its asserted level over to the new core.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every register bank reads as zero, every route points at core 0, and all core outputs are low.
- R2: The size code on `acc_size` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Write data sits in the low bits of `acc_wdata` and is moved to the byte lane given by `acc_addr[2:0]`. Data bits above the access width are ignored. The target 64-bit word becomes (old & ~mask) | (data & mask), where mask covers only the accessed bytes.
- R3: An access whose address is not a multiple of its size sets `acc_err` in that cycle and changes no state.
- R4: The banks sit at fixed byte addresses, with word index = (address − base) >> 3:
  - enable at 0x100, 4 words, one bit per interrupt;
  - route at 0x400, 32 words, one byte per interrupt;
  - status at 0x300, 4 words per core;
  - bounce at 0x200, 4 words;
  - node type at 0x000, 2 words;
  - IP map at 0x040, 1 word.
  Any other address sets `acc_err`, returns zero read data and changes no state.
- R5: A rising input line sets the interrupt's pending bit and the status bit of its routed core. `core_irq[c]` is the OR, over the interrupts routed to core c, of pending AND enabled AND core c's status bit.
- R6: The pending bit follows the input level one clock later, so a dropped input removes the interrupt from its core output.
- R7: When an enable bit goes from 0 to 1 while its interrupt is pending, the status bit at the routed core is set and the output rises. When it goes from 1 to 0 while pending, that status bit is cleared and the output falls.
- R8: Reads and writes of the status bank act on the bank of the core given by `acc_core`. Writing 1 to a bit clears it, so that interrupt is deasserted at that core.
- R9: Byte j of route word w holds the destination core of interrupt 8w+j. If a route write moves a pending interrupt, the controller clears the status bit at the old core and sets it at the new core, and the asserted level moves with it.
- R10: A route write to an interrupt that is not pending changes only the route. Status bits stay where they are, and a later input rise goes to the new core.
- R11: A route byte whose value is not below the core count (4 by default) is ignored. The stored byte and the route keep their previous value.
- R12: Node type, IP map and bounce words are stored and read back but never change any core output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Level interrupt inputs |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 12 | Byte address |
| acc_size | input | 2 | Access size code (1, 2, 4, 8 bytes) |
| acc_wdata | input | 64 | Write data in low bits |
| acc_core | input | CW | Index of the accessing core |
| acc_rdata | output | 64 | Full 64-bit word at the addressed index |
| acc_err | output | 1 | Misaligned or unmapped access |
| core_irq | output | N_CORE | One interrupt output per core |

## Verification
Routing is swept over all 256 interrupts. Each interrupt is routed to core i mod 4 and raised alone, then cleared through its own core's status bank. This separates a wrong byte-to-interrupt mapping, a wrong word/bit index in the status view and a wrong core index in the write-1-to-clear path. A single pending interrupt is then driven through enable edges, a route move, invalid route bytes and writes to the inert banks. These steps tell a level that moves with its route apart from one that is merely re-gated. Byte, half, word and doubleword writes at several lanes, together with misaligned and unmapped addresses, check the lane mask and the error rules.

// File: rtl/irc_pkg.sv
package irc_pkg;
   localparam int ADDR_W = 12;
   localparam int WIDX_W = 5;

   localparam logic [ADDR_W-1:0] NODE_BASE   = 12'h000;
   localparam logic [ADDR_W-1:0] IPMAP_BASE  = 12'h040;
   localparam logic [ADDR_W-1:0] ENABLE_BASE = 12'h100;
   localparam logic [ADDR_W-1:0] BOUNCE_BASE = 12'h200;
   localparam logic [ADDR_W-1:0] STATUS_BASE = 12'h300;
   localparam logic [ADDR_W-1:0] ROUTE_BASE  = 12'h400;

   typedef enum logic [2:0] {
      BK_NONE   = 3'd0,
      BK_NODE   = 3'd1,
      BK_IPMAP  = 3'd2,
      BK_EN     = 3'd3,
      BK_BOUNCE = 3'd4,
      BK_STAT   = 3'd5,
      BK_ROUTE  = 3'd6
   } bank_e;

   typedef struct packed {
      bank_e             bank;
      logic [WIDX_W-1:0] widx;
      logic [63:0]       mask;
      logic [63:0]       data;
      logic              misalign;
   } acc_s;

   function automatic logic [63:0] lane_mask(input logic [1:0] size, input logic [2:0] lane);
      logic [63:0] m;
      m = (size == 2'd3) ? '1 : ((64'd1 << (7'd8 << size)) - 64'd1);
      return m << {lane, 3'b000};
   endfunction
endpackage

// File: rtl/irc_acc_decode.sv
module irc_acc_decode
   import irc_pkg::*;
#(
   parameter int N_IRQ      = 256,
   parameter int NODE_WORDS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [63:0]       wdata,
   output acc_s              acc
);
   localparam int EN_WORDS    = N_IRQ / 64;
   localparam int ROUTE_WORDS = N_IRQ / 8;

   function automatic logic in_bank(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int words);
      return (int'(a) >= int'(base)) && (int'(a) < int'(base) + words * 8);
   endfunction

   logic [ADDR_W-1:0] base;

   always_comb begin
      acc.bank = BK_NONE;
      base     = '0;
      if (in_bank(addr, NODE_BASE, NODE_WORDS)) begin
         acc.bank = BK_NODE;   base = NODE_BASE;
      end else if (in_bank(addr, IPMAP_BASE, 1)) begin
         acc.bank = BK_IPMAP;  base = IPMAP_BASE;
      end else if (in_bank(addr, ENABLE_BASE, EN_WORDS)) begin
         acc.bank = BK_EN;     base = ENABLE_BASE;
      end else if (in_bank(addr, BOUNCE_BASE, EN_WORDS)) begin
         acc.bank = BK_BOUNCE; base = BOUNCE_BASE;
      end else if (in_bank(addr, STATUS_BASE, EN_WORDS)) begin
         acc.bank = BK_STAT;   base = STATUS_BASE;
      end else if (in_bank(addr, ROUTE_BASE, ROUTE_WORDS)) begin
         acc.bank = BK_ROUTE;  base = ROUTE_BASE;
      end
      acc.widx = WIDX_W'((int'(addr) - int'(base)) >>> 3);
      unique case (size)
         2'd1:    acc.misalign = addr[0];
         2'd2:    acc.misalign = |addr[1:0];
         2'd3:    acc.misalign = |addr[2:0];
         default: acc.misalign = 1'b0;
      endcase
      acc.mask = lane_mask(size, addr[2:0]);
      acc.data = (wdata << {addr[2:0], 3'b000}) & acc.mask;
   end
endmodule

// File: rtl/irc_route_map.sv
module irc_route_map
   import irc_pkg::*;
#(
   parameter int N_IRQ  = 256,
   parameter int N_CORE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [WIDX_W-1:0]   widx,
   input  logic [7:0]          be,
   input  logic [63:0]         data,
   output logic [N_IRQ*8-1:0]  route_q,
   output logic [N_IRQ*8-1:0]  route_d,
   output logic [63:0]         rd_word
);
   logic [7:0] map_q [N_IRQ];

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      localparam int W = i / 8;
      localparam int J = i % 8;
      logic [7:0] nb;
      logic       hit;

      assign nb  = data[J*8 +: 8];
      assign hit = wr && (widx == WIDX_W'(W)) && be[J];
      assign route_d[i*8 +: 8] = (hit && (int'(nb) < N_CORE)) ? nb : map_q[i];
      assign route_q[i*8 +: 8] = map_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n) map_q[i] <= '0;
         else        map_q[i] <= route_d[i*8 +: 8];
      end

      // R11: a stored route never names a core that does not exist
      p_route_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
         int'(map_q[i]) < N_CORE);
   end

   always_comb begin
      rd_word = '0;
      for (int j = 0; j < 8; j++) begin
         if (int'(widx) * 8 + j < N_IRQ) rd_word[j*8 +: 8] = map_q[int'(widx) * 8 + j];
      end
   end
endmodule

// File: rtl/irc_core_state.sv
module irc_core_state
   import irc_pkg::*;
#(
   parameter int N_IRQ  = 256,
   parameter int N_CORE = 4,
   parameter int CW     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IRQ-1:0]   irq_in,
   input  logic               en_wr,
   input  logic               st_wr,
   input  logic [WIDX_W-1:0]  widx,
   input  logic [63:0]        mask,
   input  logic [63:0]        data,
   input  logic [CW-1:0]      acc_core,
   input  logic [N_IRQ*8-1:0] route_q,
   input  logic [N_IRQ*8-1:0] route_d,
   output logic [N_IRQ-1:0]   en_q,
   output logic [N_IRQ-1:0]   pend_q,
   output logic [63:0]        en_rd_word,
   output logic [63:0]        st_rd_word,
   output logic [N_CORE-1:0]  core_irq
);
   logic [N_IRQ-1:0] en_d;
   logic [N_IRQ-1:0] st_q [N_CORE];
   logic [N_IRQ-1:0] st_d [N_CORE];

   always_comb begin
      for (int i = 0; i < N_IRQ; i++) begin
         en_d[i] = (en_wr && widx == WIDX_W'(i / 64) && mask[i % 64]) ? data[i % 64] : en_q[i];
      end
   end

   always_comb begin
      for (int c = 0; c < N_CORE; c++) begin
         for (int i = 0; i < N_IRQ; i++) begin
            logic       s;
            logic [7:0] rq, rn;
            rq = route_q[i*8 +: 8];
            rn = route_d[i*8 +: 8];
            s  = st_q[c][i];
            if (st_wr && acc_core == CW'(c) && widx == WIDX_W'(i / 64) && data[i % 64]) s = 1'b0;
            if (pend_q[i] && rq != rn && rq == 8'(c)) s = 1'b0;
            if (pend_q[i] && rq != rn && rn == 8'(c)) s = 1'b1;
            if (pend_q[i] && en_q[i] && !en_d[i] && rn == 8'(c)) s = 1'b0;
            if (pend_q[i] && !en_q[i] && en_d[i] && rn == 8'(c)) s = 1'b1;
            if (irq_in[i] && !pend_q[i] && rn == 8'(c)) s = 1'b1;
            st_d[c][i] = s;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         for (int c = 0; c < N_CORE; c++) st_q[c] <= '0;
      end else begin
         en_q   <= en_d;
         pend_q <= irq_in;
         for (int c = 0; c < N_CORE; c++) st_q[c] <= st_d[c];
      end
   end

   always_comb begin
      for (int c = 0; c < N_CORE; c++) begin
         core_irq[c] = 1'b0;
         for (int i = 0; i < N_IRQ; i++) begin
            if (pend_q[i] && en_q[i] && st_q[c][i] && route_q[i*8 +: 8] == 8'(c)) core_irq[c] = 1'b1;
         end
      end
   end

   always_comb begin
      en_rd_word = '0;
      st_rd_word = '0;
      for (int b = 0; b < 64; b++) begin
         if (int'(widx) * 64 + b < N_IRQ) begin
            en_rd_word[b] = en_q[int'(widx) * 64 + b];
            if (int'(acc_core) < N_CORE) st_rd_word[b] = st_q[acc_core][int'(widx) * 64 + b];
         end
      end
   end

   // R6: pending mirrors the input of the previous cycle
   p_pend_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pend_q == $past(irq_in)));

   for (genvar c = 0; c < N_CORE; c++) begin : g_chk
      // R5: a core output needs at least one pending and enabled source
      p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
         core_irq[c] |-> |(pend_q & en_q));
   end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irc_pkg::*;
#(
   parameter int N_IRQ      = 256,
   parameter int N_CORE     = 4,
   parameter int NODE_WORDS = 2,
   localparam int CW        = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              acc_wr,
   input  logic              acc_rd,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic [63:0]       acc_wdata,
   input  logic [CW-1:0]     acc_core,
   output logic [63:0]       acc_rdata,
   output logic              acc_err,
   output logic [N_CORE-1:0] core_irq
);
   localparam int EN_WORDS = N_IRQ / 64;

   if (N_IRQ % 64 != 0 || N_IRQ < 64 || N_IRQ > 256) begin : g_bad_irq
      $error("N_IRQ must be 64, 128, 192 or 256");
   end
   if (N_CORE < 2 || N_CORE > 256) begin : g_bad_core
      $error("N_CORE must lie in 2..256");
   end
   if (NODE_WORDS < 1 || NODE_WORDS > 8) begin : g_bad_node
      $error("NODE_WORDS must lie in 1..8");
   end

   acc_s               acc;
   logic               wr_ok;
   logic [7:0]         be;
   logic [N_IRQ*8-1:0] route_q, route_d;
   logic [N_IRQ-1:0]   en_q, pend_q;
   logic [63:0]        route_rd, en_rd, st_rd;
   logic [63:0]        nt_q [NODE_WORDS];
   logic [63:0]        bo_q [EN_WORDS];
   logic [63:0]        ip_q;

   irc_acc_decode #(.N_IRQ(N_IRQ), .NODE_WORDS(NODE_WORDS)) u_dec (
      .addr (acc_addr),
      .size (acc_size),
      .wdata(acc_wdata),
      .acc  (acc)
   );

   assign acc_err = (acc_wr | acc_rd) & (acc.misalign | (acc.bank == BK_NONE));
   assign wr_ok   = acc_wr & ~acc_err;

   always_comb begin
      for (int j = 0; j < 8; j++) be[j] = acc.mask[j*8];
   end

   irc_route_map #(.N_IRQ(N_IRQ), .N_CORE(N_CORE)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_ok && acc.bank == BK_ROUTE),
      .widx   (acc.widx),
      .be     (be),
      .data   (acc.data),
      .route_q(route_q),
      .route_d(route_d),
      .rd_word(route_rd)
   );

   irc_core_state #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .CW(CW)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .en_wr     (wr_ok && acc.bank == BK_EN),
      .st_wr     (wr_ok && acc.bank == BK_STAT),
      .widx      (acc.widx),
      .mask      (acc.mask),
      .data      (acc.data),
      .acc_core  (acc_core),
      .route_q   (route_q),
      .route_d   (route_d),
      .en_q      (en_q),
      .pend_q    (pend_q),
      .en_rd_word(en_rd),
      .st_rd_word(st_rd),
      .core_irq  (core_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q <= '0;
         for (int k = 0; k < NODE_WORDS; k++) nt_q[k] <= '0;
         for (int k = 0; k < EN_WORDS; k++)   bo_q[k] <= '0;
      end else if (wr_ok) begin
         if (acc.bank == BK_IPMAP) ip_q <= (ip_q & ~acc.mask) | acc.data;
         for (int k = 0; k < NODE_WORDS; k++) begin
            if (acc.bank == BK_NODE && acc.widx == WIDX_W'(k))
               nt_q[k] <= (nt_q[k] & ~acc.mask) | acc.data;
         end
         for (int k = 0; k < EN_WORDS; k++) begin
            if (acc.bank == BK_BOUNCE && acc.widx == WIDX_W'(k))
               bo_q[k] <= (bo_q[k] & ~acc.mask) | acc.data;
         end
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_rd && !acc_err) begin
         unique case (acc.bank)
            BK_IPMAP: acc_rdata = ip_q;
            BK_EN:    acc_rdata = en_rd;
            BK_STAT:  acc_rdata = st_rd;
            BK_ROUTE: acc_rdata = route_rd;
            BK_NODE: begin
               for (int k = 0; k < NODE_WORDS; k++)
                  if (acc.widx == WIDX_W'(k)) acc_rdata = nt_q[k];
            end
            BK_BOUNCE: begin
               for (int k = 0; k < EN_WORDS; k++)
                  if (acc.widx == WIDX_W'(k)) acc_rdata = bo_q[k];
            end
            default: acc_rdata = '0;
         endcase
      end
   end

   // R3: a misaligned write leaves enables and routes untouched
   p_misalign_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc.misalign) |=> ($stable(en_q) && $stable(route_q)));

   // R4: a write outside every bank leaves enables and routes untouched
   p_unmapped_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc.bank == BK_NONE) |=> ($stable(en_q) && $stable(route_q)));
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 256;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] irq_in = '0;
   logic          acc_wr = 1'b0;
   logic          acc_rd = 1'b0;
   logic [11:0]   acc_addr = '0;
   logic [1:0]    acc_size = '0;
   logic [63:0]   acc_wdata = '0;
   logic [1:0]    acc_core = '0;
   logic [63:0]   acc_rdata;
   logic          acc_err;
   logic [NC-1:0] core_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_route_ctrl u_irq_route_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_wdata(acc_wdata), .acc_core(acc_core),
      .acc_rdata(acc_rdata), .acc_err(acc_err), .core_irq(core_irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [1:0] sz, input logic [63:0] d,
                         input logic [1:0] core, output logic e);
      @(negedge clk);
      acc_addr = a; acc_size = sz; acc_wdata = d; acc_core = core; acc_wr = 1'b1;
      #1 e = acc_err;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, input logic [1:0] core,
                         output logic [63:0] d, output logic e);
      @(negedge clk);
      acc_addr = a; acc_size = 2'd3; acc_core = core; acc_rd = 1'b1;
      #1 d = acc_rdata; e = acc_err;
      acc_rd = 1'b0;
   endtask

   task automatic set_irq(input int i, input logic v);
      @(negedge clk);
      irq_in[i] = v;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic        e;
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 outputs low", 64'(core_irq), 64'd0);
      bus_rd(12'h000, 0, d, e); chk("R1 node word", d, 64'd0);
      bus_rd(12'h040, 0, d, e); chk("R1 ip map", d, 64'd0);
      bus_rd(12'h100, 0, d, e); chk("R1 enable", d, 64'd0);
      bus_rd(12'h200, 0, d, e); chk("R1 bounce", d, 64'd0);
      bus_rd(12'h300, 2, d, e); chk("R1 status", d, 64'd0);
      bus_rd(12'h4F8, 0, d, e); chk("R1 route word 31", d, 64'd0); chk("R1 no error", 64'(e), 64'd0);

      // R2 size-masked merges on bounce word 1
      bus_wr(12'h208, 2'd3, '1, 0, e);
      bus_wr(12'h20B, 2'd0, 64'hFFFF_FF5A, 0, e);
      bus_rd(12'h208, 0, d, e); chk("R2 byte lane 3", d, 64'hFFFF_FFFF_5AFF_FFFF);
      bus_wr(12'h20E, 2'd1, 64'h7777_1234, 0, e);
      bus_rd(12'h208, 0, d, e); chk("R2 half lane 6", d, 64'h1234_FFFF_5AFF_FFFF);
      bus_wr(12'h208, 2'd2, 64'h9_CAFE_F00D, 0, e);
      bus_rd(12'h208, 0, d, e); chk("R2 word lane 0", d, 64'h1234_FFFF_CAFE_F00D);

      // R3 misaligned accesses
      bus_wr(12'h209, 2'd1, 64'h0, 0, e); chk("R3 half misaligned err", 64'(e), 64'd1);
      bus_wr(12'h20A, 2'd2, 64'h0, 0, e); chk("R3 word misaligned err", 64'(e), 64'd1);
      bus_wr(12'h20C, 2'd3, 64'h0, 0, e); chk("R3 dword misaligned err", 64'(e), 64'd1);
      bus_rd(12'h208, 0, d, e); chk("R3 bounce unchanged", d, 64'h1234_FFFF_CAFE_F00D);
      bus_wr(12'h401, 2'd1, 64'h0101, 0, e); chk("R3 route misaligned err", 64'(e), 64'd1);
      bus_rd(12'h400, 0, d, e); chk("R3 route unchanged", d, 64'd0);

      // R4 unmapped accesses
      bus_wr(12'h080, 2'd3, '1, 0, e); chk("R4 gap write err", 64'(e), 64'd1);
      bus_wr(12'h120, 2'd3, '1, 0, e); chk("R4 past enable err", 64'(e), 64'd1);
      bus_rd(12'h7F8, 0, d, e); chk("R4 read err", 64'(e), 64'd1); chk("R4 read data zero", d, 64'd0);
      bus_rd(12'h118, 0, d, e); chk("R4 enable word 3 untouched", d, 64'd0);

      // route every source to core i mod 4 and enable all
      for (int w = 0; w < 32; w++) bus_wr(12'h400 + 12'(w * 8), 2'd3, 64'h0302_0100_0302_0100, 0, e);
      for (int w = 0; w < 4; w++)  bus_wr(12'h100 + 12'(w * 8), 2'd3, '1, 0, e);

      // R5 R8 R9 sweep over every source
      for (int i = 0; i < NI; i++) begin
         logic [1:0]  c;
         logic [11:0] sa;
         c  = 2'(i % 4);
         sa = 12'h300 + 12'((i / 64) * 8);
         set_irq(i, 1'b1);
         chk($sformatf("R5 R9 irq %0d routed", i), 64'(core_irq), 64'd1 << c);
         bus_rd(sa, c, d, e);
         chk($sformatf("R8 irq %0d status view", i), d, 64'd1 << (i % 64));
         bus_wr(sa, 2'd3, 64'd1 << (i % 64), c, e);
         chk($sformatf("R8 irq %0d w1c drops", i), 64'(core_irq), 64'd0);
         set_irq(i, 1'b0);
      end

      // R5 R7 enable gating on irq 5 (core 1)
      bus_wr(12'h100, 2'd3, 64'd0, 0, e);
      set_irq(5, 1'b1);
      chk("R5 disabled stays low", 64'(core_irq), 64'd0);
      bus_rd(12'h300, 1, d, e); chk("R5 status set on rise", d, 64'h20);
      bus_wr(12'h100, 2'd3, '1, 0, e);
      chk("R7 enable rise asserts", 64'(core_irq), 64'h2);
      bus_wr(12'h300, 2'd3, 64'h20, 1, e);
      chk("R8 cleared by core 1", 64'(core_irq), 64'd0);
      bus_wr(12'h100, 2'd0, 64'h00, 0, e);
      bus_rd(12'h300, 1, d, e); chk("R7 enable fall clears status", d, 64'd0);
      bus_wr(12'h100, 2'd0, 64'hFF, 0, e);
      chk("R7 enable rise re-asserts", 64'(core_irq), 64'h2);

      // R9 move pending irq 5 to core 3
      bus_wr(12'h405, 2'd0, 64'h03, 0, e);
      chk("R9 level moved to core 3", 64'(core_irq), 64'h8);
      bus_rd(12'h300, 3, d, e); chk("R9 new core status", d, 64'h20);
      bus_rd(12'h300, 1, d, e); chk("R9 old core status", d, 64'd0);
      bus_rd(12'h400, 0, d, e); chk("R9 route word", d, 64'h0302_0300_0302_0100);

      // R11 invalid route bytes
      bus_wr(12'h405, 2'd0, 64'h04, 0, e); chk("R11 no error", 64'(e), 64'd0);
      chk("R11 route kept", 64'(core_irq), 64'h8);
      bus_wr(12'h405, 2'd0, 64'h83, 0, e);
      chk("R11 high bit route kept", 64'(core_irq), 64'h8);
      bus_rd(12'h400, 0, d, e); chk("R11 stored byte kept", d, 64'h0302_0300_0302_0100);

      // R12 inert banks
      bus_wr(12'h040, 2'd3, '1, 0, e);
      bus_wr(12'h008, 2'd3, '1, 0, e);
      bus_wr(12'h218, 2'd3, '1, 0, e);
      chk("R12 outputs unchanged", 64'(core_irq), 64'h8);
      bus_rd(12'h040, 0, d, e); chk("R12 ip map readback", d, '1);
      bus_rd(12'h008, 0, d, e); chk("R12 node readback", d, '1);
      bus_rd(12'h218, 0, d, e); chk("R12 bounce readback", d, '1);

      // R6 input drop
      set_irq(5, 1'b0);
      chk("R6 drop removes output", 64'(core_irq), 64'd0);

      // R10 route change while not pending
      bus_wr(12'h405, 2'd0, 64'h00, 0, e);
      chk("R10 nothing asserted", 64'(core_irq), 64'd0);
      bus_rd(12'h300, 3, d, e); chk("R10 old status not moved", d, 64'h20);
      bus_rd(12'h300, 0, d, e); chk("R10 new core status empty", d, 64'd0);
      set_irq(5, 1'b1);
      chk("R10 rise goes to new core", 64'(core_irq), 64'h1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule